// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Cache Lookup

This block is the lookup path of a small first-level data cache. Each request brings a virtual address. The set is chosen from address bits that lie inside the 4 KB page offset, which the translation leaves unchanged. The tag array is therefore read in the same cycle in which a direct-mapped translation buffer converts the virtual page number into a physical page number. The stored tags are physical page numbers. The way that holds the line is found by comparing each stored tag in the selected set against the translated page number.

One cycle after a request, the block reports exactly one of three outcomes:

- a hit, with read data on a read, or with the word updated on a write;
- a miss, carrying the full physical address (and the store data on a write) for the next cache level;
- a translation fault, when the buffer has no valid entry for the page.

Translation entries are loaded through a write port. Whole lines are installed through a fill port, which places each line in a free way first and otherwise in a way picked round-robin within its set.

Because each way is exactly one page in size, the set count is derived from the page and line sizes rather than set freely. This keeps the index inside the untranslated bits for any line size.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset all outputs are low, every translation entry is invalid and every cache line is invalid.
- R2: A request accepted in one cycle produces `rsp_valid_o` in the next cycle together with exactly one of `hit_o`, `miss_o`, `fault_o`. With no response pending, all four of these outputs are low.
- R3: The set index is virtual address bits [11:6] and the 32-bit word is selected by bits [5:2]. Two virtual pages that map to the same physical page therefore hit the same line.
- R4: The translation buffer has 16 direct-mapped entries. The entry is indexed by virtual page number bits [3:0] and tagged with bits [19:4]. A page whose index matches a valid entry but whose tag differs does not translate.
- R5: A request whose page does not translate raises `fault_o` with `hit_o` and `miss_o` low, and a faulting write changes no cache data.
- R6: A hit requires a valid line whose stored physical page number equals the translated one. If the same virtual address is remapped to another physical page, it misses.
- R7: On a miss, `miss_pa_o` is {translated physical page number, virtual address bits [11:0]}. `miss_we_o` and `miss_wdata_o` carry the request's write flag and data.
- R8: A write hit replaces the addressed word in the line, and later reads return it. A write miss allocates nothing, so a later read of that address still misses.
- R9: A fill writes a 512-bit line addressed by physical address bits [31:6], with word w in line bits [32w+31:32w]. It takes the lowest invalid way of the set. When both ways are valid, it takes the way named by a per-set pointer that starts at way 0 and advances after each such replacement.
- R10: A translation write with `tlb_valid_i` low invalidates the entry, so later requests to that page fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, one per cycle |
| req_we_i | input | 1 | Request is a write |
| req_va_i | input | 32 | Virtual byte address |
| req_wdata_i | input | 32 | Store data |
| rsp_valid_o | output | 1 | Response for last cycle's request |
| hit_o | output | 1 | Line present under translated tag |
| fault_o | output | 1 | Page did not translate |
| rdata_o | output | 32 | Read data on a read hit |
| miss_o | output | 1 | Request for the next level |
| miss_we_o | output | 1 | Missed request was a write |
| miss_pa_o | output | 32 | Physical byte address of the miss |
| miss_wdata_o | output | 32 | Store data of a write miss |
| fill_i | input | 1 | Install a line |
| fill_line_addr_i | input | 26 | Physical line address (PA bits [31:6]) |
| fill_line_i | input | 512 | Line contents |
| tlb_we_i | input | 1 | Write a translation entry |
| tlb_vpn_i | input | 20 | Virtual page number of the entry |
| tlb_ppn_i | input | 20 | Physical page number of the entry |
| tlb_valid_i | input | 1 | Entry valid bit to store |

## Verification
The hardest situation to reach is one where the physical tag, and not the virtual address, decides the outcome. This means the same line reached through two virtual pages, or the same virtual address turning from hit to miss with no change to the cache. The bench gets there by programming two translation entries that share one physical page and then filling a single line. It then reaches that line through both pages, writes through one and reads through the other, and finally remaps a page and fills the same set a third and fourth time. That last step also exercises the round-robin victim choice once the set is full.

// File: rtl/vipt_pkg.sv
`timescale 1ns/1ps
package vipt_pkg;
  localparam int unsigned PAGE_W = 12;  // 4 KB pages
  typedef enum logic [1:0] {OUT_NONE, OUT_HIT, OUT_MISS, OUT_FAULT} outcome_e;
endpackage

// File: rtl/vipt_tlb.sv
`timescale 1ns/1ps
module vipt_tlb #(
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned ENTRIES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             lk_hit_o,
  output logic [PPN_W-1:0] lk_ppn_o,
  input  logic             wr_en_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic             wr_valid_i
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = VPN_W - IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];

  logic [IDX_W-1:0] lk_idx, wr_idx;
  assign lk_idx = lk_vpn_i[IDX_W-1:0];
  assign wr_idx = wr_vpn_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx] <= wr_valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx] <= wr_vpn_i[VPN_W-1:IDX_W];
      ppn_q[wr_idx] <= wr_ppn_i;
    end
  end

  assign lk_hit_o = valid_q[lk_idx] && (tag_q[lk_idx] == lk_vpn_i[VPN_W-1:IDX_W]);
  assign lk_ppn_o = ppn_q[lk_idx];

  AST_TLB_INVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_valid_i && lk_vpn_i == wr_vpn_i) |=> !lk_hit_o || $changed(lk_vpn_i)) else $error("tlb entry survived invalidate"); // R10
endmodule

// File: rtl/vipt_tags.sv
`timescale 1ns/1ps
module vipt_tags #(
  parameter int unsigned WAYS  = 2,
  parameter int unsigned SETS  = 64,
  parameter int unsigned TAG_W = 20,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned PTR_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] lk_set_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic [WAYS-1:0]  way_hit_o,
  input  logic             fill_en_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  output logic [PTR_W-1:0] fill_way_o
);
  logic [SETS-1:0]  valid_q [WAYS];
  logic [TAG_W-1:0] tag_q   [WAYS][SETS];
  logic [PTR_W-1:0] ptr_q   [SETS];

  logic             set_full;
  logic [PTR_W-1:0] victim;

  // lowest free way wins; round-robin pointer only when the set is full
  always_comb begin
    set_full = 1'b1;
    victim   = ptr_q[fill_set_i];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_q[w][fill_set_i]) begin
        victim   = PTR_W'(w);
        set_full = 1'b0;
      end
    end
  end
  assign fill_way_o = victim;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_hit_o[w] = valid_q[w][lk_set_i] && (tag_q[w][lk_set_i] == lk_tag_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) valid_q[w] <= '0;
      else if (fill_en_i && victim == PTR_W'(w)) valid_q[w][fill_set_i] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (fill_en_i && victim == PTR_W'(w)) tag_q[w][fill_set_i] <= fill_tag_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (fill_en_i && set_full) begin
      ptr_q[fill_set_i] <= (ptr_q[fill_set_i] == PTR_W'(WAYS - 1)) ? '0 : ptr_q[fill_set_i] + 1'b1;
    end
  end

  AST_WAY_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(way_hit_o)) else $error("line present in two ways"); // R6
  AST_FILL_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && !$isunknown(fill_tag_i)) |=> (lk_set_i != $past(fill_set_i)) || (lk_tag_i != $past(fill_tag_i)) || (way_hit_o != '0)) else $error("filled line not found"); // R9
endmodule

// File: rtl/vipt_data.sv
`timescale 1ns/1ps
module vipt_data #(
  parameter int unsigned WAYS   = 2,
  parameter int unsigned SETS   = 64,
  parameter int unsigned LINE_W = 512,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned PTR_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned WSEL_W = $clog2(LINE_W / DATA_W)
) (
  input  logic              clk_i,
  input  logic [SET_W-1:0]  set_i,
  input  logic [PTR_W-1:0]  way_i,
  input  logic [WSEL_W-1:0] word_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              fill_en_i,
  input  logic [SET_W-1:0]  fill_set_i,
  input  logic [PTR_W-1:0]  fill_way_i,
  input  logic [LINE_W-1:0] fill_line_i
);
  logic [LINE_W-1:0] line_q [WAYS][SETS];

  assign rd_data_o = line_q[way_i][set_i][int'(word_i) * DATA_W +: DATA_W];

  always_ff @(posedge clk_i) begin
    if (fill_en_i) line_q[fill_way_i][fill_set_i] <= fill_line_i;
    else if (wr_en_i) line_q[way_i][set_i][int'(word_i) * DATA_W +: DATA_W] <= wr_data_i;
  end
endmodule

// File: rtl/vipt_l1_lookup.sv
`timescale 1ns/1ps
module vipt_l1_lookup
  import vipt_pkg::*;
#(
  parameter int unsigned VA_W        = 32,
  parameter int unsigned PA_W        = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned LINE_B      = 64,
  parameter int unsigned WAYS        = 2,
  parameter int unsigned TLB_ENTRIES = 16,
  localparam int unsigned OFF_W  = $clog2(LINE_B),
  localparam int unsigned LINE_W = LINE_B * 8,
  localparam int unsigned VPN_W  = VA_W - PAGE_W,
  localparam int unsigned PPN_W  = PA_W - PAGE_W,
  localparam int unsigned LA_W   = PA_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic              hit_o,
  output logic              fault_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              miss_o,
  output logic              miss_we_o,
  output logic [PA_W-1:0]   miss_pa_o,
  output logic [DATA_W-1:0] miss_wdata_o,
  input  logic              fill_i,
  input  logic [LA_W-1:0]   fill_line_addr_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic              tlb_we_i,
  input  logic [VPN_W-1:0]  tlb_vpn_i,
  input  logic [PPN_W-1:0]  tlb_ppn_i,
  input  logic              tlb_valid_i
);
  // one way spans one page: index bits can never reach translated bits
  localparam int unsigned SET_W  = PAGE_W - OFF_W;
  localparam int unsigned SETS   = 1 << SET_W;
  localparam int unsigned PTR_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int unsigned BYTE_W = $clog2(DATA_W / 8);
  localparam int unsigned WSEL_W = $clog2(LINE_W / DATA_W);

  logic [SET_W-1:0]  set_idx, fill_set;
  logic [WSEL_W-1:0] word_sel;
  logic [VPN_W-1:0]  vpn;
  logic [PPN_W-1:0]  ppn, fill_tag;
  logic              tlb_hit;
  logic [WAYS-1:0]   way_hit;
  logic [PTR_W-1:0]  hit_way, fill_way;
  logic [DATA_W-1:0] rd_data;
  outcome_e          outcome;

  assign set_idx  = req_va_i[OFF_W +: SET_W];
  assign word_sel = req_va_i[BYTE_W +: WSEL_W];
  assign vpn      = req_va_i[VA_W-1:PAGE_W];
  assign fill_set = fill_line_addr_i[SET_W-1:0];
  assign fill_tag = fill_line_addr_i[LA_W-1:SET_W];

  vipt_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ENTRIES(TLB_ENTRIES)) i_tlb (
    .clk_i, .rst_ni,
    .lk_vpn_i(vpn), .lk_hit_o(tlb_hit), .lk_ppn_o(ppn),
    .wr_en_i(tlb_we_i), .wr_vpn_i(tlb_vpn_i), .wr_ppn_i(tlb_ppn_i), .wr_valid_i(tlb_valid_i)
  );

  vipt_tags #(.WAYS(WAYS), .SETS(SETS), .TAG_W(PPN_W)) i_tags (
    .clk_i, .rst_ni,
    .lk_set_i(set_idx), .lk_tag_i(ppn), .way_hit_o(way_hit),
    .fill_en_i(fill_i), .fill_set_i(fill_set), .fill_tag_i(fill_tag), .fill_way_o(fill_way)
  );

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (way_hit[w]) hit_way = PTR_W'(w);
  end

  always_comb begin
    if (!req_i)          outcome = OUT_NONE;
    else if (!tlb_hit)   outcome = OUT_FAULT;
    else if (|way_hit)   outcome = OUT_HIT;
    else                 outcome = OUT_MISS;
  end

  vipt_data #(.WAYS(WAYS), .SETS(SETS), .LINE_W(LINE_W), .DATA_W(DATA_W)) i_data (
    .clk_i,
    .set_i(set_idx), .way_i(hit_way), .word_i(word_sel), .rd_data_o(rd_data),
    .wr_en_i(outcome == OUT_HIT && req_we_i), .wr_data_i(req_wdata_i),
    .fill_en_i(fill_i), .fill_set_i(fill_set), .fill_way_i(fill_way), .fill_line_i(fill_line_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      hit_o        <= 1'b0;
      fault_o      <= 1'b0;
      miss_o       <= 1'b0;
      miss_we_o    <= 1'b0;
      rdata_o      <= '0;
      miss_pa_o    <= '0;
      miss_wdata_o <= '0;
    end else begin
      rsp_valid_o <= outcome != OUT_NONE;
      hit_o       <= outcome == OUT_HIT;
      fault_o     <= outcome == OUT_FAULT;
      miss_o      <= outcome == OUT_MISS;
      if (outcome == OUT_HIT && !req_we_i) rdata_o <= rd_data;
      if (outcome == OUT_MISS) begin
        miss_we_o    <= req_we_i;
        miss_pa_o    <= {ppn, req_va_i[PAGE_W-1:0]};
        miss_wdata_o <= req_wdata_i;
      end
    end
  end

  AST_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o) else $error("no response"); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({hit_o, miss_o, fault_o}) == 1) else $error("outcome not unique"); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(hit_o || miss_o || fault_o)) else $error("outcome without response"); // R2
  AST_FAULT_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !hit_o && !miss_o) else $error("fault with hit or miss"); // R5
  AST_MISS_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> miss_pa_o[PAGE_W-1:0] == $past(req_va_i[PAGE_W-1:0])) else $error("page offset altered"); // R7
endmodule

// File: tb/test_vipt_l1_lookup.sv
`timescale 1ns/1ps
module test_vipt_l1_lookup;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic         req, req_we;
  logic [31:0]  req_va, req_wdata;
  logic         rsp_valid, hit, fault, miss, miss_we;
  logic [31:0]  rdata, miss_pa, miss_wdata;
  logic         fill;
  logic [25:0]  fill_la;
  logic [511:0] fill_line;
  logic         tlb_we, tlb_valid;
  logic [19:0]  tlb_vpn, tlb_ppn;

  vipt_l1_lookup i_vipt_l1_lookup (
    .clk_i(clk), .rst_ni(rst_n),
    .req_i(req), .req_we_i(req_we), .req_va_i(req_va), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .hit_o(hit), .fault_o(fault), .rdata_o(rdata),
    .miss_o(miss), .miss_we_o(miss_we), .miss_pa_o(miss_pa), .miss_wdata_o(miss_wdata),
    .fill_i(fill), .fill_line_addr_i(fill_la), .fill_line_i(fill_line),
    .tlb_we_i(tlb_we), .tlb_vpn_i(tlb_vpn), .tlb_ppn_i(tlb_ppn), .tlb_valid_i(tlb_valid)
  );

  int  n_tests = 0, n_fail = 0;
  bit  done = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [19:0] ppn, input int w);
    return {ppn[15:0], 12'h0c0, 4'(w)};
  endfunction

  task automatic tlb_map(input logic [19:0] vpn, input logic [19:0] ppn, input bit v);
    @(negedge clk);
    tlb_we = 1; tlb_vpn = vpn; tlb_ppn = ppn; tlb_valid = v;
    @(negedge clk);
    tlb_we = 0;
  endtask

  task automatic fill_line_at(input logic [19:0] ppn, input logic [5:0] set);
    @(negedge clk);
    fill = 1; fill_la = {ppn, set};
    for (int w = 0; w < 16; w++) fill_line[w*32 +: 32] = word_of(ppn, w);
    @(negedge clk);
    fill = 0;
  endtask

  task automatic access(input bit we, input logic [31:0] va, input logic [31:0] wd);
    @(negedge clk);
    req = 1; req_we = we; req_va = va; req_wdata = wd;
    @(negedge clk);
    req = 0;
  endtask

  task automatic expect_hit(input string rq, input bit rd, input logic [31:0] d);
    chk(rsp_valid && hit && !miss && !fault, rq, {rsp_valid, hit, miss, fault}, 4'b1100);
    if (rd) chk(rdata == d, rq, rdata, d);
  endtask

  task automatic expect_miss(input string rq, input logic [31:0] pa, input bit we, input logic [31:0] wd);
    chk(rsp_valid && !hit && miss && !fault, rq, {rsp_valid, hit, miss, fault}, 4'b1010);
    chk(miss_pa == pa && miss_we == we, rq, {miss_we, miss_pa}, {we, pa});
    if (we) chk(miss_wdata == wd, rq, miss_wdata, wd);
  endtask

  task automatic expect_fault(input string rq);
    chk(rsp_valid && !hit && !miss && fault, rq, {rsp_valid, hit, miss, fault}, 4'b1001);
  endtask

  task automatic t_reset;
    chk({rsp_valid, hit, miss, fault, miss_we} == 0 && rdata == 0 && miss_pa == 0,
        "R1 outputs", {rsp_valid, hit, miss, fault, miss_we}, 0);
    access(0, 32'h0001_27c8, 0);
    expect_fault("R1 tlb empty");
    tlb_map(20'h00012, 20'h00345, 1);
    access(0, 32'h0001_27c8, 0);
    expect_miss("R1 cache empty", 32'h0034_57c8, 0, 0);
    @(negedge clk);
    chk(!rsp_valid && !hit && !miss && !fault, "R2 idle", {rsp_valid, hit, miss, fault}, 0);
  endtask

  task automatic t_tlb_fault;
    access(0, 32'h0002_27c8, 0);  // VPN index 2, tag differs from 0x0001
    expect_fault("R4 tag mismatch");
    access(1, 32'h0002_27c8, 32'h1234_5678);
    expect_fault("R5 write fault");
  endtask

  task automatic t_miss;
    access(1, 32'h0001_27d4, 32'hcafe_f00d);
    expect_miss("R7 write miss", 32'h0034_57d4, 1, 32'hcafe_f00d);
    access(0, 32'h0001_27d4, 0);
    expect_miss("R8 no allocate", 32'h0034_57d4, 0, 0);
  endtask

  task automatic t_fill_hit;
    fill_line_at(20'h00345, 6'h1f);
    access(0, 32'h0001_27c8, 0);
    expect_hit("R9 fill word2", 1, word_of(20'h00345, 2));
    access(0, 32'h0001_27fc, 0);
    expect_hit("R3 word15", 1, word_of(20'h00345, 15));
  endtask

  task automatic t_alias;
    tlb_map(20'h00057, 20'h00345, 1);
    access(0, 32'h0005_77c0, 0);
    expect_hit("R3 alias", 1, word_of(20'h00345, 0));
    access(1, 32'h0005_77d0, 32'hdead_beef);
    expect_hit("R8 write hit", 0, 0);
    access(0, 32'h0001_27d0, 0);
    expect_hit("R8 read back", 1, 32'hdead_beef);
    access(1, 32'h0002_27d0, 32'h0bad_0bad);  // faulting write
    access(0, 32'h0005_77d0, 0);
    expect_hit("R5 no write on fault", 1, 32'hdead_beef);
  endtask

  task automatic t_tag_compare;
    tlb_map(20'h00012, 20'h00999, 1);
    access(0, 32'h0001_27c8, 0);
    expect_miss("R6 remapped", 32'h0099_97c8, 0, 0);
  endtask

  task automatic t_replace;
    fill_line_at(20'h00999, 6'h1f);  // free way 1
    access(0, 32'h0001_27c8, 0);
    expect_hit("R9 second way", 1, word_of(20'h00999, 2));
    fill_line_at(20'h00777, 6'h1f);  // set full: pointer way 0 (0x345)
    tlb_map(20'h00058, 20'h00777, 1);
    access(0, 32'h0005_77c8, 0);
    expect_miss("R9 evicted first", 32'h0034_57c8, 0, 0);
    access(0, 32'h0001_27c8, 0);
    expect_hit("R9 kept", 1, word_of(20'h00999, 2));
    access(0, 32'h0005_87c4, 0);
    expect_hit("R9 replacement", 1, word_of(20'h00777, 1));
    fill_line_at(20'h00888, 6'h1f);  // pointer now way 1 (0x999)
    access(0, 32'h0001_27c8, 0);
    expect_miss("R9 round robin", 32'h0099_97c8, 0, 0);
    access(0, 32'h0005_87c4, 0);
    expect_hit("R9 survivor", 1, word_of(20'h00777, 1));
  endtask

  task automatic t_invalidate;
    tlb_map(20'h00058, 20'h00777, 0);
    access(0, 32'h0005_87c4, 0);
    expect_fault("R10 invalidated");
    access(0, 32'h0005_77c4, 0);
    expect_miss("R10 other entry", 32'h0034_57c4, 0, 0);
  endtask

  initial begin
    req = 0; req_we = 0; req_va = 0; req_wdata = 0;
    fill = 0; fill_la = 0; fill_line = '0;
    tlb_we = 0; tlb_vpn = 0; tlb_ppn = 0; tlb_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tlb_fault();
    t_miss();
    t_fill_hit();
    t_alias();
    t_tag_compare();
    t_replace();
    t_invalidate();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule